// File: doc/BRIEF.md
# Merging Miss Status Holding Table

This block tracks cache misses that are still waiting for memory. It is a fully associative table keyed by block address. Each occupied entry holds the requests that wait on that block, kept in arrival order, up to a merge limit. A second miss to a block that is already outstanding is merged into the existing entry, so it does not take a new one. Request identifiers are opaque tags that the block stores and returns unchanged.

Miss handling uses four operations. A combinational lookup port reports whether a block already has an entry, and whether one more request for that block would be refused. The refusal rule depends on the address: an existing block is full once its merge list has reached the limit, and a new block is full once every entry is in use. An add command appends a request to its block's list, or creates the entry. A mark command, driven by a returning fill, puts the block's entry on a queue of ready blocks. A pop command releases one waiting request per cycle, taken from the block at the head of that queue.

Commands are taken one per cycle. The command decode resolves them into one of four named commands: CMD_IDLE, CMD_POP, CMD_MARK and CMD_ADD. Every cycle returns to the decode, so the only transition is from one command cycle to the next. The head of the ready queue is either empty (`ready_o` low) or draining (`ready_o` high). It moves from empty to draining when a mark is accepted, and back to empty when the last request of the last ready block is popped.

Top module: `merge_miss_table`

## Requirements
- R1: After reset no entry is in use, `ready_o` is 0, `err_o` is 0, `lk_hit_o` is 0 for any address, and `lk_full_o` is 0.
- R2: `lk_hit_o` is 1 in the same cycle exactly when an entry for `lk_addr_i` exists.
- R3: `lk_full_o` is 1 when an entry for `lk_addr_i` exists and holds MERGE_MAX requests, or when no entry for it exists and all ENTRIES entries are in use.
- R4: An accepted add appends `add_id_i` to the list of block `add_addr_i`, and creates the entry with that single request if none exists.
- R5: An accepted mark puts the block's entry at the tail of the ready queue, and `ready_o` is 1 from the next cycle for as long as the queue is not empty.
- R6: While `ready_o` is 1, `pop_id_o` shows the oldest remaining request of the head block, and each pop removes that request, so requests leave in the order they were added.
- R7: The pop that removes the last request of a block frees its entry, so lookup misses from then on. The next ready block, in mark order, becomes the head.
- R8: An add that would exceed either limit, a mark for an absent block or for a block already on the ready queue, and a pop while `ready_o` is 0 are all refused. Each refusal sets `err_o` high for the following cycle and leaves the table unchanged.
- R9: When more than one of `pop_i`, `mark_i` and `add_i` is high, only the highest-priority command runs, in the order pop, then mark, then add. The others are refused and `err_o` is set for the following cycle.
- R10: A block that is already on the ready queue still accepts merged adds within the limit, and they are popped after its earlier requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_addr_i | input | ADDR_W | Block address to look up |
| lk_hit_o | output | 1 | An entry for the looked-up block exists |
| lk_full_o | output | 1 | An add for the looked-up block would be refused |
| add_i | input | 1 | Add or merge command |
| add_addr_i | input | ADDR_W | Block address of the add |
| add_id_i | input | ID_W | Request tag to store |
| mark_i | input | 1 | Fill returned: mark the block ready |
| mark_addr_i | input | ADDR_W | Block address of the fill |
| ready_o | output | 1 | At least one ready block is waiting to drain |
| pop_i | input | 1 | Release the oldest request of the head ready block |
| pop_id_o | output | ID_W | Tag that the next pop releases |
| err_o | output | 1 | The previous cycle's command was refused |

## Verification
The assertions assume that the inputs are free of X after reset, and that an address or tag only matters while its command bit is high. They also assume the user never issues a pop while `ready_o` is low, except in the cases where the refusal rule says it has no effect. The stimulus changes inputs only on the falling edge and drives at most the command bits that each scenario intends, including the deliberate collisions. It deliberately breaks each limit, so that the checks cover the refusal paths alongside the normal ones.

// File: rtl/mmt_pkg.sv
package mmt_pkg;
    typedef enum logic [1:0] {
        CMD_IDLE,
        CMD_POP,
        CMD_MARK,
        CMD_ADD
    } mmt_cmd_e;
endpackage

// File: rtl/mmt_match.sv
module mmt_match #(
    parameter int ENTRIES = 4,
    parameter int ADDR_W  = 16,
    localparam int EW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0]             vld_i,
    input  logic [ENTRIES-1:0][ADDR_W-1:0] tag_i,
    input  logic [ADDR_W-1:0]              key_i,
    output logic                           hit_o,
    output logic [EW-1:0]                  hit_idx_o,
    output logic                           free_o,
    output logic [EW-1:0]                  free_idx_o
);
    logic [ENTRIES-1:0] match;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = vld_i[g] && (tag_i[g] == key_i);
    end

    always_comb begin
        hit_o      = 1'b0;
        hit_idx_o  = '0;
        free_o     = 1'b0;
        free_idx_o = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit_o     = 1'b1;
                hit_idx_o = EW'(i);
            end
            if (!vld_i[i]) begin
                free_o     = 1'b1;
                free_idx_o = EW'(i);
            end
        end
    end
endmodule

// File: rtl/mmt_ready_fifo.sv
module mmt_ready_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 2,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int NW = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] push_data_i,
    input  logic         pop_i,
    output logic [W-1:0] head_o,
    output logic         nonempty_o
);
    logic [DEPTH-1:0][W-1:0] mem_q;
    logic [PW-1:0]           rd_q;
    logic [NW-1:0]           num_q;
    logic [PW:0]             wr_sum;
    logic [PW-1:0]           wr_ptr;

    always_comb begin
        wr_sum = {1'b0, rd_q} + (PW+1)'(num_q);
        if (wr_sum >= (PW+1)'(DEPTH)) wr_sum = wr_sum - (PW+1)'(DEPTH);
        wr_ptr = wr_sum[PW-1:0];
    end

    assign head_o     = mem_q[rd_q];
    assign nonempty_o = (num_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
            rd_q  <= '0;
            num_q <= '0;
        end else begin
            if (push_i) mem_q[wr_ptr] <= push_data_i;
            if (pop_i) rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            unique case ({push_i, pop_i})
                2'b10:   num_q <= num_q + 1'b1;
                2'b01:   num_q <= num_q - 1'b1;
                default: num_q <= num_q;
            endcase
        end
    end

    a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> (num_q != '0));
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (num_q < NW'(DEPTH)));
endmodule

// File: rtl/merge_miss_table.sv
module merge_miss_table
    import mmt_pkg::*;
#(
    parameter int ENTRIES   = 4,
    parameter int MERGE_MAX = 3,
    parameter int ADDR_W    = 16,
    parameter int ID_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_addr_i,
    output logic              lk_hit_o,
    output logic              lk_full_o,
    input  logic              add_i,
    input  logic [ADDR_W-1:0] add_addr_i,
    input  logic [ID_W-1:0]   add_id_i,
    input  logic              mark_i,
    input  logic [ADDR_W-1:0] mark_addr_i,
    output logic              ready_o,
    input  logic              pop_i,
    output logic [ID_W-1:0]   pop_id_o,
    output logic              err_o
);
    localparam int EW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int SW = (MERGE_MAX > 1) ? $clog2(MERGE_MAX) : 1;
    localparam int CW = $clog2(MERGE_MAX + 1);

    logic [ENTRIES-1:0]                            vld_q, rdy_q;
    logic [ENTRIES-1:0][ADDR_W-1:0]                tag_q;
    logic [ENTRIES-1:0][SW-1:0]                    hd_q;
    logic [ENTRIES-1:0][CW-1:0]                    cnt_q;
    logic [ENTRIES-1:0][MERGE_MAX-1:0][ID_W-1:0]   slot_q;

    mmt_cmd_e          cmd;
    logic              collide;
    logic [ADDR_W-1:0] cmd_key;
    logic              c_hit, c_free, p_hit, p_free;
    logic [EW-1:0]     c_idx, c_fidx, p_idx, p_fidx;
    logic [EW-1:0]     head_idx;
    logic              add_full, add_ok, mark_ok, pop_ok, pop_last, refuse;
    logic [SW:0]       tail_sum;
    logic [SW-1:0]     tail_ptr;

    // command decode: pop outranks mark, mark outranks add
    always_comb begin
        if (pop_i)       cmd = CMD_POP;
        else if (mark_i) cmd = CMD_MARK;
        else if (add_i)  cmd = CMD_ADD;
        else             cmd = CMD_IDLE;
        collide = (pop_i && (mark_i || add_i)) || (mark_i && add_i);
        cmd_key = mark_i ? mark_addr_i : add_addr_i;
    end

    mmt_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_cmd_match (
        .vld_i(vld_q), .tag_i(tag_q), .key_i(cmd_key),
        .hit_o(c_hit), .hit_idx_o(c_idx), .free_o(c_free), .free_idx_o(c_fidx)
    );

    mmt_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_lk_match (
        .vld_i(vld_q), .tag_i(tag_q), .key_i(lk_addr_i),
        .hit_o(p_hit), .hit_idx_o(p_idx), .free_o(p_free), .free_idx_o(p_fidx)
    );

    mmt_ready_fifo #(.DEPTH(ENTRIES), .W(EW)) u_ready_q (
        .clk(clk), .rst_n(rst_n),
        .push_i(mark_ok), .push_data_i(c_idx),
        .pop_i(pop_ok && pop_last),
        .head_o(head_idx), .nonempty_o(ready_o)
    );

    // outputs and acceptance
    always_comb begin
        lk_hit_o  = p_hit;
        lk_full_o = p_hit ? (cnt_q[p_idx] >= CW'(MERGE_MAX)) : !p_free;
        add_full  = c_hit ? (cnt_q[c_idx] >= CW'(MERGE_MAX)) : !c_free;
        pop_id_o  = slot_q[head_idx][hd_q[head_idx]];
        pop_last  = (cnt_q[head_idx] == CW'(1));
        add_ok    = 1'b0;
        mark_ok   = 1'b0;
        pop_ok    = 1'b0;
        refuse    = collide;
        unique case (cmd)
            CMD_POP: begin
                pop_ok = ready_o;
                if (!ready_o) refuse = 1'b1;
            end
            CMD_MARK: begin
                mark_ok = c_hit && !rdy_q[c_idx];
                if (!mark_ok) refuse = 1'b1;
            end
            CMD_ADD: begin
                add_ok = !add_full;
                if (add_full) refuse = 1'b1;
            end
            default: ;
        endcase
        tail_sum = {1'b0, hd_q[c_idx]} + (SW+1)'(cnt_q[c_idx]);
        if (tail_sum >= (SW+1)'(MERGE_MAX)) tail_sum = tail_sum - (SW+1)'(MERGE_MAX);
        tail_ptr = tail_sum[SW-1:0];
    end

    // table state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q  <= '0;
            rdy_q  <= '0;
            tag_q  <= '0;
            hd_q   <= '0;
            cnt_q  <= '0;
            slot_q <= '0;
            err_o  <= 1'b0;
        end else begin
            err_o <= refuse;
            unique case (cmd)
                CMD_POP: if (pop_ok) begin
                    if (pop_last) begin
                        vld_q[head_idx] <= 1'b0;
                        rdy_q[head_idx] <= 1'b0;
                        cnt_q[head_idx] <= '0;
                        hd_q[head_idx]  <= '0;
                    end else begin
                        cnt_q[head_idx] <= cnt_q[head_idx] - 1'b1;
                        hd_q[head_idx]  <= (hd_q[head_idx] == SW'(MERGE_MAX - 1)) ?
                                           '0 : hd_q[head_idx] + 1'b1;
                    end
                end
                CMD_MARK: if (mark_ok) rdy_q[c_idx] <= 1'b1;
                CMD_ADD: if (add_ok) begin
                    if (c_hit) begin
                        slot_q[c_idx][tail_ptr] <= add_id_i;
                        cnt_q[c_idx]            <= cnt_q[c_idx] + 1'b1;
                    end else begin
                        vld_q[c_fidx]     <= 1'b1;
                        rdy_q[c_fidx]     <= 1'b0;
                        tag_q[c_fidx]     <= add_addr_i;
                        hd_q[c_fidx]      <= '0;
                        cnt_q[c_fidx]     <= CW'(1);
                        slot_q[c_fidx][0] <= add_id_i;
                    end
                end
                default: ;
            endcase
        end
    end

    // R5: an accepted mark makes the ready queue non-empty
    a_r5_mark_then_ready: assert property (@(posedge clk) disable iff (!rst_n)
        mark_ok |=> ready_o);
    // R8: a refused lone add leaves occupancy and counts untouched
    a_r8_refused_add_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ADD && add_full) |=> ($stable(vld_q) && $stable(cnt_q)));
    // R7: the last pop of a block frees the entry it drained
    a_r7_last_pop_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_ok && pop_last) |=> !vld_q[$past(head_idx)]);
    // R9: a command collision is always flagged
    a_r9_collide_flags: assert property (@(posedge clk) disable iff (!rst_n)
        collide |=> err_o);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_chk
        // R3: no entry ever holds more than the merge limit
        a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q[g] <= CW'(MERGE_MAX));
        // R7: a ready entry is always an occupied one
        a_r7_ready_in_use: assert property (@(posedge clk) disable iff (!rst_n)
            rdy_q[g] |-> vld_q[g]);
    end
endmodule

// File: tb/merge_miss_table_bench.sv
`timescale 1ns/1ps
module merge_miss_table_bench;
    localparam int AW = 16;
    localparam int IW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] lk_addr = '0, add_addr = '0, mark_addr = '0;
    logic [IW-1:0] add_id = '0;
    logic          add = 1'b0, mark = 1'b0, pop = 1'b0;
    logic          lk_hit, lk_full, ready, err;
    logic [IW-1:0] pop_id;
    int            n_chk = 0, n_err = 0;
    bit            done = 1'b0;

    always #2 clk = ~clk;

    merge_miss_table #(.ENTRIES(4), .MERGE_MAX(3), .ADDR_W(AW), .ID_W(IW)) u_merge_miss_table (
        .clk(clk), .rst_n(rst_n),
        .lk_addr_i(lk_addr), .lk_hit_o(lk_hit), .lk_full_o(lk_full),
        .add_i(add), .add_addr_i(add_addr), .add_id_i(add_id),
        .mark_i(mark), .mark_addr_i(mark_addr),
        .ready_o(ready), .pop_i(pop), .pop_id_o(pop_id), .err_o(err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // issue one cycle of commands; returns the pop tag seen before the edge
    task automatic step(input logic p, input logic m, input logic [AW-1:0] ma,
                        input logic a, input logic [AW-1:0] aa, input logic [IW-1:0] ai,
                        output logic [IW-1:0] seen);
        @(negedge clk);
        pop = p; mark = m; mark_addr = ma; add = a; add_addr = aa; add_id = ai;
        #1 seen = pop_id;
        @(posedge clk);
        @(negedge clk);
        pop = 0; mark = 0; add = 0;
        #1;
    endtask

    task automatic look(input logic [AW-1:0] a);
        lk_addr = a;
        #1;
    endtask

    task automatic do_add(input logic [AW-1:0] a, input logic [IW-1:0] id, input logic exp_err, input string req);
        logic [IW-1:0] s;
        step(0, 0, '0, 1, a, id, s);
        check(req, err, exp_err);
    endtask

    task automatic do_mark(input logic [AW-1:0] a, input logic exp_err, input string req);
        logic [IW-1:0] s;
        step(0, 1, a, 0, '0, '0, s);
        check(req, err, exp_err);
    endtask

    task automatic do_pop(input logic [IW-1:0] exp_id, input string req);
        logic [IW-1:0] s;
        step(1, 0, '0, 0, '0, '0, s);
        check(req, s, exp_id);
        check(req, err, 0);
    endtask

    task automatic t_reset();
        look(16'h0100);
        check("R1 ready", ready, 0);
        check("R1 err", err, 0);
        check("R1 hit", lk_hit, 0);
        check("R1 full", lk_full, 0);
    endtask

    task automatic t_merge_limit();
        do_add(16'h0100, 8'h11, 0, "R4 create");
        look(16'h0100);
        check("R2 hit after create", lk_hit, 1);
        check("R3 not full", lk_full, 0);
        do_add(16'h0100, 8'h12, 0, "R4 merge");
        do_add(16'h0100, 8'h13, 0, "R4 merge");
        look(16'h0100);
        check("R3 merge full", lk_full, 1);
        do_add(16'h0100, 8'h14, 1, "R8 over merge limit");
        check("R8 still full", lk_full, 1);
    endtask

    task automatic t_capacity();
        do_add(16'h0200, 8'h21, 0, "R4 B");
        do_add(16'h0300, 8'h31, 0, "R4 C");
        do_add(16'h0400, 8'h41, 0, "R4 D");
        look(16'h0500);
        check("R2 new miss", lk_hit, 0);
        check("R3 table full", lk_full, 1);
        do_add(16'h0500, 8'h51, 1, "R8 over entry limit");
        look(16'h0500);
        check("R8 no entry made", lk_hit, 0);
    endtask

    task automatic t_bad_mark_pop();
        logic [IW-1:0] s;
        do_mark(16'h0500, 1, "R8 mark absent");
        check("R8 no ready", ready, 0);
        step(1, 0, '0, 0, '0, '0, s);
        check("R8 pop empty", err, 1);
        check("R8 pop empty ready", ready, 0);
    endtask

    task automatic t_drain_order();
        do_mark(16'h0300, 0, "R5 mark C");
        check("R5 ready", ready, 1);
        do_mark(16'h0100, 0, "R5 mark A");
        do_mark(16'h0300, 1, "R8 mark twice");
        do_pop(8'h31, "R7 first marked first");
        look(16'h0300);
        check("R7 C released", lk_hit, 0);
        check("R7 still ready", ready, 1);
        do_pop(8'h11, "R6 oldest");
        do_pop(8'h12, "R6 second");
        do_pop(8'h13, "R6 third");
        check("R5 ready drops", ready, 0);
        look(16'h0100);
        check("R7 A released", lk_hit, 0);
    endtask

    task automatic t_collide();
        logic [IW-1:0] s;
        step(0, 1, 16'h0200, 1, 16'h0100, 8'h51, s);
        check("R9 mark beats add err", err, 1);
        check("R9 mark done", ready, 1);
        look(16'h0100);
        check("R9 add dropped", lk_hit, 0);
        step(1, 0, '0, 1, 16'h0700, 8'h71, s);
        check("R9 pop beats add id", s, 8'h21);
        check("R9 pop beats add err", err, 1);
        check("R9 queue drained", ready, 0);
        look(16'h0700);
        check("R9 add dropped 2", lk_hit, 0);
    endtask

    task automatic t_merge_ready();
        do_mark(16'h0400, 0, "R10 mark D");
        do_add(16'h0400, 8'h42, 0, "R10 merge into ready");
        do_pop(8'h41, "R10 older first");
        do_pop(8'h42, "R10 merged second");
        check("R10 empty", ready, 0);
        look(16'h0400);
        check("R7 D released", lk_hit, 0);
        do_add(16'h0600, 8'h61, 0, "R4 reuse entry");
        look(16'h0600);
        check("R2 reuse hit", lk_hit, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_merge_limit();
        t_capacity();
        t_bad_mark_pop();
        t_drain_order();
        t_collide();
        t_merge_ready();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule